// File: doc/BRIEF.md
# Gated hue histogram accumulator

This block builds a hue histogram over one scanned block of pixels. Each pixel arrives with a hue bin index (0 to 35, one bin per 10 degrees of hue) and two pass flags: one from a minimum-intensity test and one from a minimum-saturation test. Only pixels that pass both tests add to the count of their bin. A pixel that fails either test is not counted in any bin.

A start-of-block strobe clears every counter. An end-of-block strobe freezes the counts. The frozen counts form the block's colour signature: a flat 36 x 12-bit vector (432 bits) that a downstream template store or matcher can take directly. The same counts can also be read one bin per cycle over a 12-bit bus, in ascending bin order, under a read-enable.

A block can hold from 1 pixel up to 128 x 64 = 8192 pixels, which is more than a 12-bit count can hold. For that reason each counter saturates rather than wraps.

Top module: `hue_hist_acc`

## Requirements
- R1: After reset, every 12-bit field of `signature_o` is zero, and `sig_valid_o` and `rd_valid_o` are low.
- R2: A qualified pixel adds one to the count of bin `hue_bin_i`, seen at `signature_o[hue_bin_i*12 +: 12]` one cycle later. A qualified pixel has `pix_valid_i`, `int_pass_i` and `sat_pass_i` all 1 and `hue_bin_i` below 36.
- R3: A pixel with either pass flag at 0, with `pix_valid_i` at 0, or with `hue_bin_i` of 36 or more changes no count.
- R4: `sob_i` sets every count to zero in the next cycle. A qualified pixel in the same cycle leaves its bin at 1.
- R5: A count that has reached 4095 stays at 4095 when further qualified pixels arrive.
- R6: `eob_i` counts a qualified pixel in the same cycle and raises `sig_valid_o` one cycle later. From then until the next `sob_i`, pixels are ignored and `signature_o` holds steady.
- R7: While `sig_valid_o` is high, each cycle with `rd_en_i` high yields, one cycle later, `rd_valid_o` = 1 with `rd_bin_o` and `rd_data_o` set to that bin and its count. The bins go 0, 1, ..., 35 and then wrap to 0. The sequence restarts at bin 0 after each `sob_i` or `eob_i`. While `sig_valid_o` is low, `rd_en_i` yields no `rd_valid_o`.
- R8: `rd_last_o` is high exactly on the read beat that carries bin 35.
- R9: When `sob_i` and `eob_i` are high in the same cycle, the start strobe wins: the counts clear and `sig_valid_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sob_i | input | 1 | Start of block: clear all counts |
| eob_i | input | 1 | End of block: freeze the counts |
| pix_valid_i | input | 1 | A pixel is present this cycle |
| hue_bin_i | input | 6 | Hue bin index of the pixel |
| int_pass_i | input | 1 | Pixel passed the intensity test |
| sat_pass_i | input | 1 | Pixel passed the saturation test |
| sig_valid_o | output | 1 | Counts frozen; signature valid |
| signature_o | output | 432 | Bin b count at bits [b*12 +: 12] |
| rd_en_i | input | 1 | Request one readout beat |
| rd_valid_o | output | 1 | Readout beat valid |
| rd_bin_o | output | 6 | Bin index of the beat |
| rd_data_o | output | 12 | Count of the bin |
| rd_last_o | output | 1 | Beat carries the final bin |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it:
- a pixel's count appears on `signature_o` one edge after the pixel;
- the clear appears one edge after `sob_i`;
- `sig_valid_o` rises one edge after `eob_i`;
- each readout beat appears one edge after the `rd_en_i` cycle that requested it.

The bench drives every input on the falling edge and holds it for one full cycle. It compares all outputs on the next falling edge, so each comparison lands on the cycle in which the result is due. The bench computes the expected histogram arithmetically from the pixels it sends. It checks the ignore cases (pixels after the freeze, failing flags, out-of-range bins) by comparing the whole signature right after that stimulus.

// File: rtl/hue_hist_pkg.sv
package hue_hist_pkg;
  localparam int unsigned HUE_BINS  = 36;
  localparam int unsigned HUE_CNT_W = 12;
endpackage

// File: rtl/hue_hist_qual.sv
// Pixel qualification and one-hot bin decode.
module hue_hist_qual #(
  parameter int unsigned NUM_BINS = 36,
  parameter int unsigned BIN_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic                pix_valid_i,
  input  logic                int_pass_i,
  input  logic                sat_pass_i,
  input  logic [BIN_W-1:0]    hue_bin_i,
  output logic [NUM_BINS-1:0] inc_o
);
  logic gate;
  assign gate = accept_i & pix_valid_i & int_pass_i & sat_pass_i;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_dec
    assign inc_o[b] = gate && (hue_bin_i == BIN_W'(b));
  end

  // R3: a pixel failing either test never reaches a counter
  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_pass_i || !sat_pass_i || !pix_valid_i) |-> (inc_o == '0));
  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_o));
endmodule

// File: rtl/hue_hist_bin.sv
// One saturating bin counter with synchronous clear.
module hue_hist_bin #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clr_i)                    cnt_o <= CNT_W'(inc_i);  // pixel counts after clear
    else if (inc_i && cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
  end

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o <= CNT_W'(1)));
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o == CntMax) |=> (cnt_o == CntMax));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/hue_hist_rd.sv
// Sequential one-bin-per-beat readout.
module hue_hist_rd #(
  parameter int unsigned NUM_BINS = 36,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned BIN_W    = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      restart_i,
  input  logic                      en_i,
  input  logic [NUM_BINS*CNT_W-1:0] cnt_flat_i,
  output logic                      rd_valid_o,
  output logic [BIN_W-1:0]          rd_bin_o,
  output logic [CNT_W-1:0]          rd_data_o,
  output logic                      rd_last_o
);
  localparam logic [BIN_W-1:0] LastBin = BIN_W'(NUM_BINS - 1);

  logic [BIN_W-1:0] ptr_q;
  logic             at_last;
  assign at_last = (ptr_q == LastBin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_bin_o   <= '0;
      rd_data_o  <= '0;
      rd_last_o  <= 1'b0;
    end else begin
      rd_valid_o <= en_i && !restart_i;
      if (restart_i) begin
        ptr_q     <= '0;
        rd_last_o <= 1'b0;
      end else if (en_i) begin
        rd_bin_o  <= ptr_q;
        rd_data_o <= cnt_flat_i[int'(ptr_q)*CNT_W +: CNT_W];
        rd_last_o <= at_last;
        ptr_q     <= at_last ? '0 : ptr_q + 1'b1;
      end
    end
  end

  p_last_bin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_last_o) |-> (rd_bin_o == LastBin));
  p_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_last_o && en_i && !restart_i) |=>
      (rd_bin_o == $past(rd_bin_o) + 1'b1));
endmodule

// File: rtl/hue_hist_acc.sv
module hue_hist_acc
  import hue_hist_pkg::*;
#(
  parameter int unsigned NUM_BINS = HUE_BINS,
  parameter int unsigned CNT_W    = HUE_CNT_W,
  parameter int unsigned BIN_W    = $clog2(NUM_BINS),
  parameter int unsigned SIG_W    = NUM_BINS * CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sob_i,
  input  logic             eob_i,
  input  logic             pix_valid_i,
  input  logic [BIN_W-1:0] hue_bin_i,
  input  logic             int_pass_i,
  input  logic             sat_pass_i,
  output logic             sig_valid_o,
  output logic [SIG_W-1:0] signature_o,
  input  logic             rd_en_i,
  output logic             rd_valid_o,
  output logic [BIN_W-1:0] rd_bin_o,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_last_o
);
  logic                frozen_q;
  logic                accept;
  logic [NUM_BINS-1:0] inc;

  // start strobe beats end strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frozen_q <= 1'b0;
    else if (sob_i) frozen_q <= 1'b0;
    else if (eob_i) frozen_q <= 1'b1;
  end

  assign accept      = !frozen_q || sob_i;
  assign sig_valid_o = frozen_q;

  hue_hist_qual #(.NUM_BINS(NUM_BINS), .BIN_W(BIN_W)) u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .pix_valid_i (pix_valid_i),
    .int_pass_i  (int_pass_i),
    .sat_pass_i  (sat_pass_i),
    .hue_bin_i   (hue_bin_i),
    .inc_o       (inc)
  );

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    hue_hist_bin #(.CNT_W(CNT_W)) u_bin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (sob_i),
      .inc_i  (inc[b]),
      .cnt_o  (signature_o[b*CNT_W +: CNT_W])
    );
  end

  hue_hist_rd #(.NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .BIN_W(BIN_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (sob_i || eob_i),
    .en_i       (rd_en_i && frozen_q),
    .cnt_flat_i (signature_o),
    .rd_valid_o (rd_valid_o),
    .rd_bin_o   (rd_bin_o),
    .rd_data_o  (rd_data_o),
    .rd_last_o  (rd_last_o)
  );

  p_freeze_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && !sob_i) |=> $stable(signature_o));
  p_rd_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frozen_q |=> !rd_valid_o);
  p_sob_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sob_i |=> !sig_valid_o);
endmodule

// File: tb/sim_hue_hist_acc.sv
module sim_hue_hist_acc;
  localparam int NB = 36;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sob = 0, eob = 0, pv = 0, ip = 0, sp = 0, rd_en = 0;
  logic [5:0] hue = '0;
  logic sig_valid, rd_valid, rd_last;
  logic [NB*CW-1:0] sig;
  logic [5:0] rd_bin;
  logic [CW-1:0] rd_data;

  int exp_cnt [NB];
  bit m_frozen;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hue_hist_acc u0 (
    .clk_i(clk), .rst_ni(rst_n), .sob_i(sob), .eob_i(eob),
    .pix_valid_i(pv), .hue_bin_i(hue), .int_pass_i(ip), .sat_pass_i(sp),
    .sig_valid_o(sig_valid), .signature_o(sig), .rd_en_i(rd_en),
    .rd_valid_o(rd_valid), .rd_bin_o(rd_bin), .rd_data_o(rd_data),
    .rd_last_o(rd_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_sig(input string req);
    int bad = 0;
    for (int b = 0; b < NB; b++)
      if (int'(sig[b*CW +: CW]) != exp_cnt[b]) begin
        if (bad == 0)
          $display("FAIL %s: bin %0d actual %0d expected %0d",
                   req, b, sig[b*CW +: CW], exp_cnt[b]);
        bad++;
      end
    tests++;
    if (bad != 0) fails++;
  endtask

  // one cycle of stimulus, called at a falling edge
  task automatic step(input logic s, input logic e, input logic v,
                      input logic i_ok, input logic s_ok, input int h);
    bit q;
    sob = s; eob = e; pv = v; ip = i_ok; sp = s_ok; hue = 6'(h);
    if (s) for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
    q = v && i_ok && s_ok && h < NB && (!m_frozen || s);
    if (q && exp_cnt[h] < 4095) exp_cnt[h]++;
    if (s) m_frozen = 0; else if (e) m_frozen = 1;
    @(negedge clk);
    sob = 0; eob = 0; pv = 0; ip = 0; sp = 0; hue = '0;
  endtask

  task automatic read_all(input string tag);
    rd_en = 1;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      if (i == NB - 1) rd_en = 0;
      chk({tag, " R7 valid"}, int'(rd_valid), 1);
      chk({tag, " R7 bin"}, int'(rd_bin), i);
      chk({tag, " R7 data"}, int'(rd_data), exp_cnt[i]);
      chk({tag, " R8 last"}, int'(rd_last), (i == NB - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk({tag, " R7 idle"}, int'(rd_valid), 0);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
    m_frozen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sig_valid", int'(sig_valid), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk_sig("R1 counts");

    // R7: read request before freeze gives nothing
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R7 gated", int'(rd_valid), 0);

    // R2/R3 sweep over all bins and all flag combinations
    step(1, 0, 0, 0, 0, 0);
    for (int b = 0; b < NB; b++) begin
      for (int n = 0; n <= (b * 7) % 5; n++) step(0, 0, 1, 1, 1, b);
      for (int f = 0; f < 7; f++) step(0, 0, f[0], f[1], f[2], b);
    end
    chk_sig("R2 sweep");
    step(0, 0, 1, 1, 1, 36);
    step(0, 0, 1, 1, 1, 63);
    chk_sig("R3 out of range");

    // R6 end strobe with pixel, then ignored pixels
    step(0, 1, 1, 1, 1, 0);
    chk("R6 sig_valid", int'(sig_valid), 1);
    chk_sig("R6 pixel with eob");
    for (int b = 0; b < NB; b += 5) step(0, 0, 1, 1, 1, b);
    chk_sig("R6 frozen");
    chk("R6 still valid", int'(sig_valid), 1);

    // R7/R8 readout twice (wrap)
    read_all("first");
    read_all("wrap");

    // R4 clear with a pixel in the same cycle
    step(1, 0, 1, 1, 1, 7);
    chk_sig("R4 clear");
    chk("R4 sig_valid", int'(sig_valid), 0);

    // R5 saturation
    for (int n = 0; n < 4100; n++) step(0, 0, 1, 1, 1, 5);
    chk_sig("R5 saturate");
    chk("R5 bin5", int'(sig[5*CW +: CW]), 4095);

    // freeze, partial read, then R9 sob+eob together
    step(0, 1, 0, 0, 0, 0);
    rd_en = 1; @(negedge clk); @(negedge clk); rd_en = 0;
    chk("R7 second beat", int'(rd_bin), 1);
    step(1, 1, 1, 1, 1, 3);
    chk("R9 sig_valid", int'(sig_valid), 0);
    chk_sig("R9 cleared");

    // R7 restart at bin 0 after eob
    step(0, 1, 0, 0, 0, 0);
    read_all("restart");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule